// File: doc/BRIEF.md
# Dual-Register Input Capture Channel

This block is one channel of a timer. It watches a single input line and copies the value of a free-running 16-bit time base into its registers when chosen edges arrive. A capture register A holds the newest sample. Behind it sits a staged path: an internal stage register B2 and a software-visible register B1. Software reads the samples, an event flag and the pin level through a small register port. Read data appears one cycle after the read strobe.

Two measuring modes exist. In period mode, every edge of one selected polarity is captured. The first capture after the control register is written only primes the channel. Every later capture raises the flag. In pulse-width mode, the leading edge is parked in the internal stage. The trailing edge is latched into A, the parked value moves to B1 and the flag is raised, so the width is A minus B1.

Software can take A and B1 as one consistent pair with a coherent two-part read. While that read is open, A keeps capturing. Moves into the B path are held back and then done in the cycle after the read closes.

Top module: `cap_chan`

## Requirements
- R1: The mode field is bits [3:0] of CTRL (address 0). Code 4'b0010 selects period mode and 4'b0001 selects pulse-width mode. Any other code performs no capture, so A, B1 and the flag stay unchanged on edges.
- R2: The polarity bit is CTRL bit 4 (1 = rising, 0 = falling). In period mode a qualifying edge latches the time base into A (address 2). It then moves B1 to B2 and A to B1, so B (address 3) equals A. Edges of the other polarity are ignored.
- R3: After any write to CTRL, the next qualifying period-mode capture leaves the flag unchanged. Every later capture sets it.
- R4: The flag is STAT (address 1) bit 0. It stays set until a STAT write with bit 0 = 1 clears it. A capture that sets the flag in the same cycle as a clear wins.
- R5: STAT bit 1 gives the input level after a two-flop synchronizer. It is read-only.
- R6: A read of COH_HI (address 4) returns A and snapshots B1 in the same cycle. The following read of COH_LO (address 5) returns that snapshot, even if B1 is due to change in the meantime.
- R7: From a COH_HI read until the COH_LO read, captures still latch A. The transfers into B1/B2, and the flag set that belongs to them, wait until the cycle after the COH_LO read.
- R8: In pulse-width mode the leading edge (per polarity) stores the time base in the internal stage only. The trailing edge latches A, copies the stage into B1 and sets the flag, so the width is A minus B1.
- R9: After reset all registers read zero and the channel is idle. Reads return data one cycle after the read strobe.
- R10: Edges are found by comparing the synchronized input with its previous sample. A capture takes place three clock edges after the input changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tbase | input | 16 | Free-running time base value |
| cap_in | input | 1 | Input signal being measured |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 5 | Write data |
| bus_rdata | output | 16 | Read data, valid the cycle after bus_rd |

## Verification
The bench builds the channel with its default parameters: a 16-bit time base and a two-stage synchronizer. With these settings every capture lands a fixed three edges after an input change. The bench holds the time base steady around each edge, so each captured value is known exactly. This lets it line up a flag clear with a capture in the same cycle, and place an edge inside an open coherent read to watch the held-back transfer.

// File: rtl/cap_pkg.sv
package cap_pkg;
  localparam int unsigned MODE_W = 4;
  localparam int unsigned ADDR_W = 3;
  localparam int unsigned WD_W   = MODE_W + 1;

  localparam logic [MODE_W-1:0] MODE_PERIOD = 4'b0010;
  localparam logic [MODE_W-1:0] MODE_PULSE  = 4'b0001;

  localparam logic [ADDR_W-1:0] ADR_CTRL   = 3'd0;
  localparam logic [ADDR_W-1:0] ADR_STAT   = 3'd1;
  localparam logic [ADDR_W-1:0] ADR_A      = 3'd2;
  localparam logic [ADDR_W-1:0] ADR_B      = 3'd3;
  localparam logic [ADDR_W-1:0] ADR_COH_HI = 3'd4;
  localparam logic [ADDR_W-1:0] ADR_COH_LO = 3'd5;
endpackage

// File: rtl/cap_edge_det.sv
module cap_edge_det #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  output logic level_o,
  output logic rise_o,
  output logic fall_o
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic [SYNC_STAGES-1:0] sync_n;
  logic                   prev_q;

  generate
    for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_sync
      if (i == 0) begin : g_first
        assign sync_n[i] = pin_i;
      end else begin : g_next
        assign sync_n[i] = sync_q[i-1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= sync_n;
      prev_q <= sync_q[SYNC_STAGES-1];
    end
  end

  assign level_o = sync_q[SYNC_STAGES-1];
  assign rise_o  = level_o & ~prev_q;
  assign fall_o  = ~level_o & prev_q;

  // R10
  no_double_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rise_o |=> !rise_o);
endmodule

// File: rtl/cap_core.sv
module cap_core
  import cap_pkg::*;
#(
  parameter int unsigned TW = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [TW-1:0]     tbase_i,
  input  logic [MODE_W-1:0] mode_i,
  input  logic              pol_i,
  input  logic              rise_i,
  input  logic              fall_i,
  input  logic              coh_active_i,
  input  logic              trk_clr_i,
  input  logic              flag_clr_i,
  output logic [TW-1:0]     a_o,
  output logic [TW-1:0]     b1_o,
  output logic              flag_o
);
  logic [TW-1:0] a_q, a_n, b1_q, b1_n, b2_q, b2_n;
  logic          flag_q, flag_n, seen_q, seen_n, armed_q, armed_n;
  logic          pend_q, pend_n, pfl_q, pfl_n, flag_set;
  logic          is_period, is_pulse, lead, trail;

  assign is_period = (mode_i == MODE_PERIOD);
  assign is_pulse  = (mode_i == MODE_PULSE);
  assign lead      = pol_i ? rise_i : fall_i;
  assign trail     = pol_i ? fall_i : rise_i;

  always_comb begin
    a_n      = a_q;
    b1_n     = b1_q;
    b2_n     = b2_q;
    seen_n   = seen_q;
    armed_n  = armed_q;
    pend_n   = pend_q;
    pfl_n    = pfl_q;
    flag_set = 1'b0;
    if (trk_clr_i) begin
      seen_n  = 1'b0;
      armed_n = 1'b0;
      pend_n  = 1'b0;
      pfl_n   = 1'b0;
    end else begin
      // finish a transfer that waited for a coherent read
      if (pend_q && !coh_active_i) begin
        pend_n = 1'b0;
        if (is_period) begin
          b2_n = b1_q;
          b1_n = a_q;
        end else begin
          b1_n = b2_q;
        end
        if (pfl_q) flag_set = 1'b1;
      end
      if (is_period && lead) begin
        a_n    = tbase_i;
        seen_n = 1'b1;
        if (coh_active_i) begin
          pend_n = 1'b1;
          pfl_n  = seen_q;
        end else begin
          b2_n = b1_n;
          b1_n = tbase_i;
          if (seen_q) flag_set = 1'b1;
        end
      end
      if (is_pulse) begin
        if (lead && !pend_q) begin
          b2_n    = tbase_i;
          armed_n = 1'b1;
        end
        if (trail && armed_q) begin
          a_n     = tbase_i;
          armed_n = 1'b0;
          if (coh_active_i) begin
            pend_n = 1'b1;
            pfl_n  = 1'b1;
          end else begin
            b1_n     = b2_q;
            flag_set = 1'b1;
          end
        end
      end
    end
    flag_n = flag_set ? 1'b1 : (flag_q & ~flag_clr_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q     <= '0;
      b1_q    <= '0;
      b2_q    <= '0;
      flag_q  <= 1'b0;
      seen_q  <= 1'b0;
      armed_q <= 1'b0;
      pend_q  <= 1'b0;
      pfl_q   <= 1'b0;
    end else begin
      a_q     <= a_n;
      b1_q    <= b1_n;
      b2_q    <= b2_n;
      flag_q  <= flag_n;
      seen_q  <= seen_n;
      armed_q <= armed_n;
      pend_q  <= pend_n;
      pfl_q   <= pfl_n;
    end
  end

  assign a_o    = a_q;
  assign b1_o   = b1_q;
  assign flag_o = flag_q;

  // R2
  period_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (is_period && lead && !trk_clr_i) |=> (a_q == $past(tbase_i)));
  // R7
  b1_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    coh_active_i |=> $stable(b1_q));
  // R4
  flag_set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flag_set |=> flag_q);
  // R4
  flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_clr_i && !flag_set) |=> !flag_q);
endmodule

// File: rtl/cap_bus.sv
module cap_bus
  import cap_pkg::*;
#(
  parameter int unsigned TW = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [WD_W-1:0]   wdata_i,
  input  logic [TW-1:0]     a_i,
  input  logic [TW-1:0]     b1_i,
  input  logic              flag_i,
  input  logic              level_i,
  output logic [TW-1:0]     rdata_o,
  output logic [MODE_W-1:0] mode_o,
  output logic              pol_o,
  output logic              trk_clr_o,
  output logic              flag_clr_o,
  output logic              coh_active_o
);
  logic [MODE_W-1:0] mode_q, mode_n;
  logic              pol_q, pol_n;
  logic [TW-1:0]     hold_q, hold_n, rdata_q, rdata_n;
  logic              coh_busy_q, coh_busy_n;
  logic              ctrl_wr, coh_start, coh_end;

  assign ctrl_wr   = wr_i && (addr_i == ADR_CTRL);
  assign coh_start = rd_i && (addr_i == ADR_COH_HI);
  assign coh_end   = rd_i && (addr_i == ADR_COH_LO);

  always_comb begin
    mode_n     = mode_q;
    pol_n      = pol_q;
    hold_n     = hold_q;
    coh_busy_n = coh_busy_q;
    rdata_n    = rdata_q;
    if (ctrl_wr) begin
      mode_n = wdata_i[MODE_W-1:0];
      pol_n  = wdata_i[MODE_W];
    end
    if (coh_start) begin
      hold_n     = b1_i;
      coh_busy_n = 1'b1;
    end else if (coh_end) begin
      coh_busy_n = 1'b0;
    end
    if (rd_i) begin
      case (addr_i)
        ADR_CTRL:   rdata_n = TW'({pol_q, mode_q});
        ADR_STAT:   rdata_n = TW'({level_i, flag_i});
        ADR_A:      rdata_n = a_i;
        ADR_B:      rdata_n = b1_i;
        ADR_COH_HI: rdata_n = a_i;
        ADR_COH_LO: rdata_n = coh_busy_q ? hold_q : b1_i;
        default:    rdata_n = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q     <= '0;
      pol_q      <= 1'b0;
      hold_q     <= '0;
      coh_busy_q <= 1'b0;
      rdata_q    <= '0;
    end else begin
      mode_q     <= mode_n;
      pol_q      <= pol_n;
      hold_q     <= hold_n;
      coh_busy_q <= coh_busy_n;
      rdata_q    <= rdata_n;
    end
  end

  assign rdata_o      = rdata_q;
  assign mode_o       = mode_q;
  assign pol_o        = pol_q;
  assign trk_clr_o    = ctrl_wr;
  assign flag_clr_o   = wr_i && (addr_i == ADR_STAT) && wdata_i[0];
  assign coh_active_o = coh_busy_q | coh_start;

  // R6
  coh_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
    coh_start |=> (coh_busy_q && rdata_q == $past(a_i)));
  // R6
  coh_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (coh_end && !coh_start) |=> !coh_busy_q);
endmodule

// File: rtl/cap_chan.sv
module cap_chan
  import cap_pkg::*;
#(
  parameter int unsigned TW          = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [TW-1:0]     tbase,
  input  logic              cap_in,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [WD_W-1:0]   bus_wdata,
  output logic [TW-1:0]     bus_rdata
);
  logic              level, rise, fall;
  logic [MODE_W-1:0] mode;
  logic              pol, trk_clr, flag_clr, coh_active, flag;
  logic [TW-1:0]     a_val, b1_val;

  cap_edge_det #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk(clk), .rst_n(rst_n), .pin_i(cap_in),
    .level_o(level), .rise_o(rise), .fall_o(fall));

  cap_core #(.TW(TW)) u_core (
    .clk(clk), .rst_n(rst_n), .tbase_i(tbase), .mode_i(mode), .pol_i(pol),
    .rise_i(rise), .fall_i(fall), .coh_active_i(coh_active),
    .trk_clr_i(trk_clr), .flag_clr_i(flag_clr),
    .a_o(a_val), .b1_o(b1_val), .flag_o(flag));

  cap_bus #(.TW(TW)) u_bus (
    .clk(clk), .rst_n(rst_n), .wr_i(bus_wr), .rd_i(bus_rd),
    .addr_i(bus_addr), .wdata_i(bus_wdata), .a_i(a_val), .b1_i(b1_val),
    .flag_i(flag), .level_i(level), .rdata_o(bus_rdata), .mode_o(mode),
    .pol_o(pol), .trk_clr_o(trk_clr), .flag_clr_o(flag_clr),
    .coh_active_o(coh_active));
endmodule

// File: tb/cap_chan_tb.sv
module cap_chan_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 5;
  // {tbase, expected A, expected B, 14'b0, pin, expected flag}
  localparam logic [63:0] VEC [NV] = '{
    {16'h1000, 16'h1000, 16'h1000, 14'd0, 1'b1, 1'b0},
    {16'h1050, 16'h1000, 16'h1000, 14'd0, 1'b0, 1'b0},
    {16'h1100, 16'h1100, 16'h1100, 14'd0, 1'b1, 1'b1},
    {16'h1200, 16'h1100, 16'h1100, 14'd0, 1'b0, 1'b1},
    {16'h1250, 16'h1250, 16'h1250, 14'd0, 1'b1, 1'b1}
  };

  logic        clk, rst_n, cap_in, bus_wr, bus_rd;
  logic [15:0] tbase, bus_rdata, rv;
  logic [2:0]  bus_addr;
  logic [4:0]  bus_wdata;
  int checks = 0, failures = 0;
  bit done = 0;

  cap_chan u_dut (.clk(clk), .rst_n(rst_n), .tbase(tbase), .cap_in(cap_in),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata));

  initial clk = 0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [4:0] d);
    bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    bus_rd = 1; bus_addr = a;
    @(negedge clk);
    bus_rd = 0;
    d = bus_rdata;
  endtask

  task automatic step(input logic [15:0] t, input logic p);
    tbase = t; cap_in = p;
    repeat (5) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst_n = 0; cap_in = 0; bus_wr = 0; bus_rd = 0; bus_addr = 0;
    bus_wdata = 0; tbase = 16'h0777;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R9 reset state
    rd(3'd0, rv); check("R9 ctrl", rv, 16'h0000);
    rd(3'd1, rv); check("R9 stat", rv, 16'h0000);
    rd(3'd2, rv); check("R9 A", rv, 16'h0000);
    rd(3'd3, rv); check("R9 B", rv, 16'h0000);
    // R1 idle mode: edge ignored
    step(16'h0900, 1'b1); step(16'h0950, 1'b0);
    rd(3'd2, rv); check("R1 idle A", rv, 16'h0000);

    // R2 R3 table: period mode, rising
    wr(3'd0, 5'h12);
    for (int i = 0; i < NV; i++) begin
      step(VEC[i][63:48], VEC[i][1]);
      rd(3'd2, rv); check("R2 A", rv, VEC[i][47:32]);
      rd(3'd3, rv); check("R2 B", rv, VEC[i][31:16]);
      rd(3'd1, rv); check("R3 flag", {15'd0, rv[0]}, {15'd0, VEC[i][0]});
    end

    // R4 clear, R5 pin level (pin high)
    wr(3'd1, 5'h01);
    rd(3'd1, rv); check("R4 R5 stat", rv, 16'h0002);

    // R2 R3 falling polarity after CTRL write
    wr(3'd0, 5'h02);
    step(16'h2000, 1'b0);
    rd(3'd2, rv); check("R2 fall A", rv, 16'h2000);
    rd(3'd1, rv); check("R3 first no flag", rv, 16'h0000);
    step(16'h2100, 1'b1);
    rd(3'd2, rv); check("R2 wrong edge A", rv, 16'h2000);
    step(16'h2200, 1'b0);
    rd(3'd2, rv); check("R2 fall A2", rv, 16'h2200);
    rd(3'd1, rv); check("R3 second flag", rv, 16'h0001);

    // R4 set wins over clear in the same cycle
    wr(3'd1, 5'h01);
    rd(3'd1, rv); check("R4 cleared", rv, 16'h0000);
    step(16'h2300, 1'b1);
    tbase = 16'h2400; cap_in = 0;
    @(negedge clk); @(negedge clk);
    wr(3'd1, 5'h01);
    repeat (2) @(negedge clk);
    rd(3'd1, rv); check("R4 set wins", rv, 16'h0001);
    rd(3'd2, rv); check("R10 capture A", rv, 16'h2400);

    // R1 idle mode code
    wr(3'd0, 5'h00);
    step(16'h2500, 1'b1); step(16'h2600, 1'b0);
    rd(3'd2, rv); check("R1 idle A2", rv, 16'h2400);

    // R8 pulse width, rising leading edge
    wr(3'd1, 5'h01);
    wr(3'd0, 5'h11);
    step(16'h3000, 1'b1);
    rd(3'd2, rv); check("R8 lead A", rv, 16'h2400);
    rd(3'd3, rv); check("R8 lead B", rv, 16'h2400);
    rd(3'd1, rv); check("R8 lead flag", rv, 16'h0002);
    step(16'h3040, 1'b0);
    rd(3'd2, rv); check("R8 trail A", rv, 16'h3040);
    rd(3'd3, rv); check("R8 trail B", rv, 16'h3000);
    rd(3'd1, rv); check("R8 flag", rv, 16'h0001);

    // R6 R7 coherent read with deferred transfer
    wr(3'd0, 5'h12);
    wr(3'd1, 5'h01);
    step(16'h4000, 1'b1);
    rd(3'd3, rv); check("R2 B first", rv, 16'h4000);
    step(16'h4010, 1'b0);
    rd(3'd4, rv); check("R6 coh hi", rv, 16'h4000);
    step(16'h4100, 1'b1);
    rd(3'd2, rv); check("R7 A during coh", rv, 16'h4100);
    rd(3'd3, rv); check("R7 B held", rv, 16'h4000);
    rd(3'd1, rv); check("R7 flag held", rv, 16'h0002);
    rd(3'd5, rv); check("R6 coh lo", rv, 16'h4000);
    repeat (2) @(negedge clk);
    rd(3'd3, rv); check("R7 B after", rv, 16'h4100);
    rd(3'd1, rv); check("R7 flag after", rv, 16'h0003);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule